// File: doc/BRIEF.md
# Up/Down Counter Timer with Compare Reload

This block is a counter timer with one compare register, an eight-bit control register and a two-bit mode register. A small register bus reaches all three. In general-purpose mode the counter steps up on each prescaled tick. It either runs freely or returns to zero when it equals the compare value. In up/down mode an external direction input picks the step direction. In variant A of that mode, an underflow can load the compare value into the counter. The block drives the counter value and two one-clock event pulses, one for a compare match and one for an underflow.

Each control bit acts only in the mode it belongs to. Clear-on-match has no effect in up/down mode. Reload-on-underflow has no effect in general-purpose mode and in up/down variant B. While the counter is running, software can change only the run bit. Writes to any other control bit are dropped.

Top module: `updown_timer`

## Requirements
- R1: After a synchronous reset the control, compare and mode registers and the counter read 0, and both pulse outputs are low.
- R2: The control register layout is as follows. Bit 6 is run. Bit 3 is reload-enable. Bit 2 is clear-enable. Bits 1:0 are a stored clear-source field. Bits 7, 5 and 4 always read 0. A bus write to address 0 loads bits 7:0 of the write data. A bit write sets bit `bit_sel` of the control register to `bit_val`.
- R3: While run is 1, a byte write or a bit write to the control register can change bit 6 only. Every other bit keeps its value.
- R4: While run is 0 the counter holds its value, and ticks have no effect. When run is set again, counting continues from the held value.
- R5: In general-purpose mode (mode bit 0 = 0), each counted tick adds one to the counter, wrapping from all ones to 0. With clear-enable at 0 the counter never clears.
- R6: In general-purpose mode with clear-enable at 1, a counted tick taken while the counter equals the compare register sets the counter to 0.
- R7: In up/down mode (mode bit 0 = 1), a counted tick adds one when `dir_up` is 1, wrapping from all ones to 0. It subtracts one when `dir_up` is 0.
- R8: A downward tick taken at 0 is an underflow. Unless R9 applies, the counter becomes all ones. `uflow_o` is high for the one clock that follows the tick.
- R9: An underflow loads the compare value instead only in variant A (mode bit 1 = 0) with reload-enable at 1. In general-purpose mode and in variant B, reload-enable has no effect.
- R10: Clear-enable has no effect in up/down mode.
- R11: `match_o` is high for the one clock that follows any counted tick taken while the counter equals the compare register. This holds in every mode and for either setting of clear-enable.
- R12: Reads are combinational. Address 0 returns control, 1 returns compare, 2 returns mode ({variant-B select, up/down}) and 3 returns the counter, each zero-extended. A write to address 1 or 2 loads the compare or mode register. The counter and both pulses change at the same clock edge that samples the tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bit_wr | input | 1 | Single-bit write strobe for the control register |
| bit_sel | input | 3 | Control bit index for a bit write |
| bit_val | input | 1 | Value for a bit write |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tick | input | 1 | Prescaled count tick |
| dir_up | input | 1 | Count direction in up/down mode |
| count_o | output | CNT_W | Counter value |
| match_o | output | 1 | Compare match pulse |
| uflow_o | output | 1 | Underflow pulse |

## Verification
The bench uses an 8-bit counter so that wraps and compare hits come around within a few hundred ticks. General-purpose mode runs freely with a random tick pattern. It then runs a sweep of sixteen compare values with clear enabled. This separates the wrap at all ones from the clear at the compare value and checks the match pulse in both settings. Up/down mode runs every combination of variant, reload-enable and clear-enable. Each combination gets a direction stream biased downward, to force underflows and separate reload from wrap, and then one biased upward, to show the upward wrap and that clear-enable is ignored. Byte and bit writes made while running and while stopped show which control bits are protected and which are reserved.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;

    localparam int CTRL_RUN_BIT  = 6;
    localparam int CTRL_RLD_BIT  = 3;
    localparam int CTRL_CLR_BIT  = 2;
    localparam logic [7:0] CTRL_RUN_MASK = 8'h40;
    localparam logic [7:0] CTRL_RW_MASK  = 8'h4F;

    typedef struct packed {
        logic       rsv7;
        logic       run;
        logic [1:0] rsv54;
        logic       reload_en;
        logic       clear_en;
        logic [1:0] clr_src;
    } ctrl_t;

    typedef struct packed {
        logic variant_b;
        logic updown;
    } mode_t;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_CMP  = 2'd1,
        ADR_MODE = 2'd2,
        ADR_CNT  = 2'd3
    } addr_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_DEC,
        ACT_ZERO,
        ACT_RELOAD,
        ACT_TOP
    } act_e;

    // Merge a candidate control value into the current one; a running
    // counter lets only the run bit through.
    function automatic logic [7:0] ctrl_merge(input logic [7:0] cur,
                                              input logic [7:0] cand);
        logic [7:0] res;
        if (cur[CTRL_RUN_BIT])
            res = (cur & ~CTRL_RUN_MASK) | (cand & CTRL_RUN_MASK);
        else
            res = cand & CTRL_RW_MASK;
        return res;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import updown_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bit_wr,
    input  logic [2:0]       bit_sel,
    input  logic             bit_val,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] cmp_o,
    output mode_t            mode_o
);

    logic [7:0] ctrl_bits;
    logic [7:0] ctrl_cand;
    logic       wr_ctrl;

    assign wr_ctrl = bus_wr && (addr_e'(bus_addr) == ADR_CTRL);

    always_comb begin
        ctrl_cand = ctrl_bits;
        if (wr_ctrl)
            ctrl_cand = bus_wdata[7:0];
        else if (bit_wr)
            ctrl_cand[bit_sel] = bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_bits <= '0;
            cmp_o     <= '0;
            mode_o    <= '0;
        end else begin
            if (wr_ctrl || bit_wr)
                ctrl_bits <= ctrl_merge(ctrl_bits, ctrl_cand);
            if (bus_wr && (addr_e'(bus_addr) == ADR_CMP))
                cmp_o <= bus_wdata[CNT_W-1:0];
            if (bus_wr && (addr_e'(bus_addr) == ADR_MODE))
                mode_o <= mode_t'(bus_wdata[1:0]);
        end
    end

    assign ctrl_o = ctrl_t'(ctrl_bits);

    assert_protect_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits[CTRL_RUN_BIT] && (wr_ctrl || bit_wr))
        |=> $stable({ctrl_bits[7], ctrl_bits[5:0]}))
        else $error("protected control bit changed while running");

endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import updown_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             tick,
    input  logic             dir_up,
    input  logic             run,
    input  logic             reload_en,
    input  logic             clear_en,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output act_e             act,
    output logic             match_evt,
    output logic             uflow_evt
);

    logic hit;
    assign hit = (cnt == cmp);

    always_comb begin
        act       = ACT_HOLD;
        match_evt = 1'b0;
        uflow_evt = 1'b0;
        if (tick && run) begin
            match_evt = hit;
            if (!mode.updown) begin
                act = (clear_en && hit) ? ACT_ZERO : ACT_INC;
            end else if (dir_up) begin
                act = ACT_INC;
            end else if (cnt == '0) begin
                uflow_evt = 1'b1;
                act = (!mode.variant_b && reload_en) ? ACT_RELOAD : ACT_TOP;
            end else begin
                act = ACT_DEC;
            end
        end
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import updown_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    input  logic             match_evt,
    input  logic             uflow_evt,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o,
    output logic             uflow_o
);

    logic [CNT_W-1:0] nxt;

    always_comb begin
        unique case (act)
            ACT_INC:    nxt = cnt_o + 1'b1;
            ACT_DEC:    nxt = cnt_o - 1'b1;
            ACT_ZERO:   nxt = '0;
            ACT_RELOAD: nxt = cmp;
            ACT_TOP:    nxt = '1;
            default:    nxt = cnt_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o   <= '0;
            match_o <= 1'b0;
            uflow_o <= 1'b0;
        end else begin
            cnt_o   <= nxt;
            match_o <= match_evt;
            uflow_o <= uflow_evt;
        end
    end

    assert_uflow_from_zero_R8: assert property (@(posedge clk) disable iff (rst)
        uflow_o |-> ($past(cnt_o) == '0))
        else $error("underflow pulse without a step from zero");

endmodule

// File: rtl/updown_timer.sv
module updown_timer
    import updown_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bit_wr,
    input  logic [2:0]       bit_sel,
    input  logic             bit_val,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tick,
    input  logic             dir_up,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o,
    output logic             uflow_o
);

    ctrl_t            ctrl_q;
    mode_t            mode_q;
    logic [CNT_W-1:0] cmp_q;
    act_e             act;
    logic             match_evt;
    logic             uflow_evt;

    tmr_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bit_wr    (bit_wr),
        .bit_sel   (bit_sel),
        .bit_val   (bit_val),
        .ctrl_o    (ctrl_q),
        .cmp_o     (cmp_q),
        .mode_o    (mode_q)
    );

    tmr_step #(.CNT_W(CNT_W)) u_step (
        .tick      (tick),
        .dir_up    (dir_up),
        .run       (ctrl_q.run),
        .reload_en (ctrl_q.reload_en),
        .clear_en  (ctrl_q.clear_en),
        .mode      (mode_q),
        .cnt       (count_o),
        .cmp       (cmp_q),
        .act       (act),
        .match_evt (match_evt),
        .uflow_evt (uflow_evt)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .match_evt (match_evt),
        .uflow_evt (uflow_evt),
        .cmp       (cmp_q),
        .cnt_o     (count_o),
        .match_o   (match_o),
        .uflow_o   (uflow_o)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (addr_e'(bus_addr))
            ADR_CTRL: bus_rdata[7:0]       = ctrl_q;
            ADR_CMP:  bus_rdata[CNT_W-1:0] = cmp_q;
            ADR_MODE: bus_rdata[1:0]       = mode_q;
            default:  bus_rdata[CNT_W-1:0] = count_o;
        endcase
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(tick && ctrl_q.run) |=> $stable(count_o))
        else $error("counter moved without a counted tick");

    assert_gp_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (match_o && $past(!mode_q.updown && ctrl_q.clear_en)) |-> (count_o == '0))
        else $error("match with clear enabled did not zero the counter");

    assert_reload_R9: assert property (@(posedge clk) disable iff (rst)
        (uflow_o && $past(!mode_q.variant_b && ctrl_q.reload_en)) |-> (count_o == $past(cmp_q)))
        else $error("reload did not load the compare value");

    assert_wrap_top_R8: assert property (@(posedge clk) disable iff (rst)
        (uflow_o && !$past(!mode_q.variant_b && ctrl_q.reload_en)) |-> (count_o == '1))
        else $error("underflow without reload did not wrap to all ones");

    assert_uflow_mode_R10: assert property (@(posedge clk) disable iff (rst)
        uflow_o |-> $past(mode_q.updown))
        else $error("underflow outside up/down mode");

endmodule

// File: tb/updown_timer_bench.sv
`timescale 1ns/1ps
module updown_timer_bench;

    localparam int W = 8;
    localparam logic [W-1:0] TOP = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bit_wr = 1'b0;
    logic [2:0]  bit_sel = '0;
    logic        bit_val = 1'b0;
    logic [15:0] bus_rdata;
    logic        tick = 1'b0;
    logic        dir_up = 1'b0;
    logic [W-1:0] count_o;
    logic        match_o;
    logic        uflow_o;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_cmp = '0;
    logic [7:0]   m_ctrl = '0;
    logic [1:0]   m_mode = '0;
    logic [15:0]  lfsr = 16'hACE1;

    always #2 clk = ~clk;

    updown_timer #(.CNT_W(W), .BUS_W(16)) u_updown_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bit_wr(bit_wr), .bit_sel(bit_sel),
        .bit_val(bit_val), .bus_rdata(bus_rdata), .tick(tick),
        .dir_up(dir_up), .count_o(count_o), .match_o(match_o),
        .uflow_o(uflow_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R2/R3: expected control value after a write
    function automatic logic [7:0] exp_ctrl(input logic [7:0] cur, input logic [7:0] cand);
        if (cur[6]) return (cur & 8'hBF) | (cand & 8'h40);
        return cand & 8'h4F;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            2'd0: m_ctrl = exp_ctrl(m_ctrl, d[7:0]);
            2'd1: m_cmp = d[W-1:0];
            2'd2: m_mode = d[1:0];
            default: ;
        endcase
    endtask

    task automatic bwr(input int idx, input logic v);
        logic [7:0] c;
        bit_wr = 1'b1; bit_sel = 3'(idx); bit_val = v;
        @(posedge clk); @(negedge clk);
        bit_wr = 1'b0;
        c = m_ctrl; c[idx] = v;
        m_ctrl = exp_ctrl(m_ctrl, c);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input logic up);
        logic [W-1:0] n;
        logic em, eu;
        string rq;
        n = m_cnt; em = 0; eu = 0;
        rq = "R4";
        if (m_ctrl[6]) begin
            em = (m_cnt == m_cmp);
            if (!m_mode[0]) begin
                rq = "R5";
                if (m_ctrl[2] && em) begin n = '0; rq = "R6"; end
                else n = m_cnt + 1'b1;
            end else begin
                rq = m_ctrl[2] ? "R10" : "R7";
                if (up) n = m_cnt + 1'b1;
                else if (m_cnt == '0) begin
                    eu = 1;
                    if (!m_mode[1] && m_ctrl[3]) begin n = m_cmp; rq = "R9"; end
                    else begin n = TOP; rq = "R8"; end
                end else n = m_cnt - 1'b1;
            end
        end
        tick = 1'b1; dir_up = up;
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
        m_cnt = n;
        chk(rq, int'(count_o), int'(n));
        chk("R11", int'(match_o), int'(em));
        chk("R8", int'(uflow_o), int'(eu));
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, d); chk("R1", int'(d), 0);
        rd(2'd1, d); chk("R1", int'(d), 0);
        rd(2'd2, d); chk("R1", int'(d), 0);
        rd(2'd3, d); chk("R1", int'(d), 0);
        chk("R1", int'(match_o), 0);
        chk("R1", int'(uflow_o), 0);

        // R2 layout, reserved bits, bit writes
        wr(2'd0, 16'h00B0); rd(2'd0, d); chk("R2", int'(d), 8'h00);
        wr(2'd0, 16'h003F); rd(2'd0, d); chk("R2", int'(d), 8'h0F);
        wr(2'd0, 16'h0000);
        bwr(3, 1'b1); rd(2'd0, d); chk("R2", int'(d), 8'h08);
        bwr(1, 1'b1); rd(2'd0, d); chk("R2", int'(d), 8'h0A);
        bwr(7, 1'b1); rd(2'd0, d); chk("R2", int'(d), 8'h0A);
        bwr(5, 1'b1); rd(2'd0, d); chk("R2", int'(d), 8'h0A);

        // R12 register read back
        wr(2'd1, 16'h005A); rd(2'd1, d); chk("R12", int'(d), 16'h005A);
        wr(2'd2, 16'h0003); rd(2'd2, d); chk("R12", int'(d), 16'h0003);
        wr(2'd2, 16'h0000); rd(2'd2, d); chk("R12", int'(d), 16'h0000);

        // R5/R9: general-purpose free run, reload-enable set but ignored
        wr(2'd1, 16'h0050);
        wr(2'd0, 16'h0048);
        for (int i = 0; i < 300; i++) begin
            lfsr = lfsr_next(lfsr);
            if (lfsr[0]) step(lfsr[1]);
            else begin @(posedge clk); @(negedge clk); chk("R4", int'(count_o), int'(m_cnt)); end
        end
        rd(2'd3, d); chk("R12", int'(d), int'(m_cnt));

        // R3 protection while running
        wr(2'd0, 16'h004F); rd(2'd0, d); chk("R3", int'(d), 8'h48);
        bwr(2, 1'b1);       rd(2'd0, d); chk("R3", int'(d), 8'h48);
        bwr(3, 1'b0);       rd(2'd0, d); chk("R3", int'(d), 8'h48);
        bwr(6, 1'b0);       rd(2'd0, d); chk("R3", int'(d), 8'h08);

        // R4 hold then resume
        for (int i = 0; i < 20; i++) step(1'b1);
        bwr(6, 1'b1);
        for (int i = 0; i < 10; i++) step(1'b1);
        wr(2'd0, 16'h0000);

        // R6 clear sweep over compare values
        for (int k = 0; k < 16; k++) begin
            wr(2'd0, 16'h0000);
            wr(2'd1, 16'(k * 17));
            wr(2'd0, 16'h0044);
            for (int i = 0; i < 600; i++) step(1'b1);
        end
        wr(2'd0, 16'h0000);

        // R7-R10 up/down mode over variant, reload-enable, clear-enable
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, 16'h0000);
            wr(2'd2, {14'd0, c[0], 1'b1});
            wr(2'd1, 16'(8'h30 + c * 5));
            wr(2'd0, {8'd0, 1'b0, 1'b1, 2'b00, c[1], c[2], 2'b00});
            for (int i = 0; i < 400; i++) begin
                lfsr = lfsr_next(lfsr);
                step(lfsr[2:0] == 3'd0);
            end
            for (int i = 0; i < 400; i++) begin
                lfsr = lfsr_next(lfsr);
                step(lfsr[2:0] != 3'd0);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule